// File: doc/BRIEF.md
# Idle-Channel Region Prefetch Scheduler

This block sits on the miss side of a second-level cache and feeds prefetch requests to a multi-channel DRAM controller. Each demand miss names a naturally aligned region of neighbouring cache blocks. The block keeps a small table of recently missed regions, and each region holds one pending bit per block. Each cycle the block picks one pending block and shows it on a probe port, where the cache answers whether the block is already resident or already outstanding. A block that is resident or outstanding is dropped. Any other block is issued as a prefetch with a flag that tells the cache to fill it at the least-recently-used position of its set.

A block is considered only when its memory channel has no demand request waiting, so demand traffic never waits behind a prefetch. The block keeps one open-row register per DRAM bank. The controller updates these registers for demand accesses, and the block updates them for its own prefetches. When a pending block maps to the row already open in its bank, it is chosen ahead of blocks that would need an activation.

All addresses are cache-block addresses. With the default parameters, a region is 8 blocks. Bits [1:0] select the channel, bits [2:0] form the bank index (one bank bit above the channel bits), and bits [15:5] are the DRAM row. The parameters must keep the channel and bank bits inside the region offset, and the row bits above it.

Top module: `region_pf_sched`

## Requirements
- R1: A demand miss to a region that is not tracked takes the least recently touched of the 8 table entries. The new entry has every block of the region pending except the missed block. A miss to a region that is already tracked makes that entry the most recently touched and clears the missed block's pending bit.
- R2: A prefetch is never issued on a channel whose bit in `dem_pend` is set. The channel is block-address bits [1:0].
- R3: When any eligible pending block maps to the row held open for its bank, the issued block is such a row hit. The bank index is bits [2:0] and the row is bits [15:5]. The open row of a bank is set by `act_*` and by every issued prefetch. When both update the same bank in one cycle, `act_*` wins.
- R4: A candidate for which `probe_hit` is high in its probe cycle is cleared and is never issued.
- R5: Each pending block is issued at most once, and its bit is cleared in the cycle it is issued.
- R6: When no eligible block is a row hit, the block chooses the lowest-numbered eligible block of the least recently touched region that has one.
- R7: Among row-hit candidates, the block chooses the most recently touched region, and then its lowest-numbered hit block.
- R8: Every issued prefetch has `pf_lowpri` set.
- R9: During reset and after it, with no misses, nothing is probed or issued, and no bank has an open row.
- R10: When a region's entry is replaced, its remaining pending blocks are discarded and never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A demand miss is reported this cycle |
| miss_addr | input | ADDR_W | Block address of the demand miss |
| dem_pend | input | 2**CH_W | Per channel: a demand request is waiting |
| act_valid | input | 1 | The controller accessed a row for a demand request |
| act_bank | input | CH_W+BK_W | Bank index of that access |
| act_row | input | ADDR_W-CH_W-BK_W-COL_W | Row opened by that access |
| probe_valid | output | 1 | A candidate is being checked this cycle |
| probe_addr | output | ADDR_W | Block address of the candidate |
| probe_hit | input | 1 | The candidate is resident or outstanding (same cycle) |
| pf_valid | output | 1 | A prefetch is issued this cycle |
| pf_addr | output | ADDR_W | Block address of the prefetch |
| pf_lowpri | output | 1 | Fill the prefetched block at the lowest replacement priority |

## Verification
Assertions check several properties on every cycle. No prefetch ever goes out on a channel with a waiting demand request. An issued block is a row hit whenever a row-hit candidate exists. A block just issued or just squashed is never presented again in the next cycle. Some behaviour shows only in the bench's scenarios, because it depends on history: the exact issue order across regions of different age, the interleaving that follows as issued prefetches open rows for a second region in the same row, the refresh that lets a region survive replacement, the discarding of an evicted region's blocks, and the exclusion of the demand block itself.

// File: rtl/region_pf_sched.sv
module region_pf_sched #(
  parameter int ADDR_W  = 16,
  parameter int REG_W   = 3,
  parameter int CH_W    = 2,
  parameter int BK_W    = 1,
  parameter int COL_W   = 2,
  parameter int ENTRIES = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 miss_valid,
  input  logic [ADDR_W-1:0]                    miss_addr,
  input  logic [(1<<CH_W)-1:0]                 dem_pend,
  input  logic                                 act_valid,
  input  logic [CH_W+BK_W-1:0]                 act_bank,
  input  logic [ADDR_W-CH_W-BK_W-COL_W-1:0]    act_row,
  output logic                                 probe_valid,
  output logic [ADDR_W-1:0]                    probe_addr,
  input  logic                                 probe_hit,
  output logic                                 pf_valid,
  output logic [ADDR_W-1:0]                    pf_addr,
  output logic                                 pf_lowpri
);

  localparam int NBLK    = 1 << REG_W;
  localparam int BNK_W   = CH_W + BK_W;
  localparam int NBANKS  = 1 << BNK_W;
  localparam int ROW_LSB = BNK_W + COL_W;
  localparam int ROW_W   = ADDR_W - ROW_LSB;
  localparam int BASE_W  = ADDR_W - REG_W;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [BASE_W-1:0]  base [ENTRIES];
  logic [NBLK-1:0]    pend [ENTRIES];
  logic [IDX_W-1:0]   rank [ENTRIES];
  logic [NBANKS-1:0]  row_vld;
  logic [ROW_W-1:0]   row_q [NBANKS];

  logic [NBLK-1:0]    elig [ENTRIES];
  logic [NBLK-1:0]    hitv [ENTRIES];

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      for (int j = 0; j < NBLK; j++) begin
        elig[e][j] = vld[e] & pend[e][j] & ~dem_pend[CH_W'(j)];
        hitv[e][j] = elig[e][j] & row_vld[BNK_W'(j)] &
                     (row_q[BNK_W'(j)] == base[e][BASE_W-1:ROW_LSB-REG_W]);
      end
    end
  end

  logic             any_hit, any_el, sel_valid;
  logic [IDX_W-1:0] hit_e, el_e, hit_rk, el_rk, sel_e;
  logic [NBLK-1:0]  sel_vec;
  logic [REG_W-1:0] sel_j;

  always_comb begin
    any_hit = 1'b0;
    any_el  = 1'b0;
    hit_e   = '0;
    el_e    = '0;
    hit_rk  = '1;
    el_rk   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (|hitv[e] && (!any_hit || rank[e] < hit_rk)) begin
        any_hit = 1'b1;
        hit_e   = IDX_W'(e);
        hit_rk  = rank[e];
      end
      if (|elig[e] && (!any_el || rank[e] > el_rk)) begin
        any_el = 1'b1;
        el_e   = IDX_W'(e);
        el_rk  = rank[e];
      end
    end
    sel_e   = any_hit ? hit_e : el_e;
    sel_vec = any_hit ? hitv[sel_e] : elig[sel_e];
    sel_j   = '0;
    for (int j = NBLK - 1; j >= 0; j--)
      if (sel_vec[j]) sel_j = REG_W'(j);
  end

  assign sel_valid   = any_hit | any_el;
  assign probe_valid = sel_valid;
  assign probe_addr  = {base[sel_e], sel_j};
  assign pf_valid    = sel_valid & ~probe_hit;
  assign pf_addr     = probe_addr;
  assign pf_lowpri   = pf_valid;

  logic [BASE_W-1:0] miss_base;
  logic [REG_W-1:0]  miss_ofs;
  logic              m_hit;
  logic [IDX_W-1:0]  m_e, vict_e, tgt_e, old_rank;

  assign miss_base = miss_addr[ADDR_W-1:REG_W];
  assign miss_ofs  = miss_addr[REG_W-1:0];

  always_comb begin
    m_hit  = 1'b0;
    m_e    = '0;
    vict_e = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (vld[e] && base[e] == miss_base) begin
        m_hit = 1'b1;
        m_e   = IDX_W'(e);
      end
      if (rank[e] == IDX_W'(ENTRIES - 1)) vict_e = IDX_W'(e);
    end
    tgt_e    = m_hit ? m_e : vict_e;
    old_rank = rank[tgt_e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      row_vld <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        base[e] <= '0;
        pend[e] <= '0;
        rank[e] <= IDX_W'(e);
      end
      for (int b = 0; b < NBANKS; b++) row_q[b] <= '0;
    end else begin
      if (sel_valid) pend[sel_e][sel_j] <= 1'b0;
      if (miss_valid) begin
        if (m_hit) begin
          pend[tgt_e][miss_ofs] <= 1'b0;
        end else begin
          vld[tgt_e]  <= 1'b1;
          base[tgt_e] <= miss_base;
          pend[tgt_e] <= ~(NBLK'(1) << miss_ofs);
        end
        for (int e = 0; e < ENTRIES; e++) begin
          if (IDX_W'(e) == tgt_e) rank[e] <= '0;
          else if (rank[e] < old_rank) rank[e] <= rank[e] + 1'b1;
        end
      end
      if (pf_valid) begin
        row_vld[pf_addr[BNK_W-1:0]] <= 1'b1;
        row_q[pf_addr[BNK_W-1:0]]   <= pf_addr[ADDR_W-1:ROW_LSB];
      end
      if (act_valid) begin
        row_vld[act_bank] <= 1'b1;
        row_q[act_bank]   <= act_row;
      end
    end
  end

  AST_IDLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !dem_pend[pf_addr[CH_W-1:0]]); // R2

  AST_ROW_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && any_hit) |-> (row_vld[pf_addr[BNK_W-1:0]] &&
                               row_q[pf_addr[BNK_W-1:0]] == pf_addr[ADDR_W-1:ROW_LSB])); // R3

  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_hit) |=> !(probe_valid && probe_addr == $past(probe_addr))); // R4

  AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |=> !(probe_valid && probe_addr == $past(pf_addr))); // R5

endmodule

// File: tb/region_pf_sched_tb.sv
module region_pf_sched_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [15:0] miss_addr;
  logic [3:0]  dem_pend;
  logic        act_valid;
  logic [2:0]  act_bank;
  logic [10:0] act_row;
  logic        probe_valid;
  logic [15:0] probe_addr;
  logic        probe_hit;
  logic        pf_valid;
  logic [15:0] pf_addr;
  logic        pf_lowpri;

  logic [15:0] pres0, pres1;
  logic [15:0] exp_q [$];
  string       cur_req = "R9";
  int          n_chk = 0;
  int          n_fail = 0;

  region_pf_sched u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .dem_pend(dem_pend), .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_lowpri(pf_lowpri)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign probe_hit = probe_valid && (probe_addr == pres0 || probe_addr == pres1);

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [15:0] act_v, input logic [15:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual %h expected %h", req, what, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] e;
    if (rst_n && pf_valid) begin
      chk(pf_lowpri == 1'b1, "R8", "low-priority flag", 16'(pf_lowpri), 16'h1);
      chk(dem_pend[pf_addr[1:0]] == 1'b0, "R2", "demand pending on prefetch channel",
          16'(dem_pend), 16'h0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected prefetch", pf_addr, 16'hxxxx);
      end else begin
        e = exp_q.pop_front();
        chk(pf_addr == e, cur_req, "prefetch address", pf_addr, e);
      end
    end
  end

  task automatic miss(input logic [15:0] a);
    @(posedge clk); #1;
    miss_valid = 1'b1;
    miss_addr  = a;
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic act(input logic [15:0] a);
    @(posedge clk); #1;
    act_valid = 1'b1;
    act_bank  = a[2:0];
    act_row   = a[15:5];
    @(posedge clk); #1;
    act_valid = 1'b0;
  endtask

  task automatic set_pend(input logic [3:0] p);
    @(posedge clk); #1;
    dem_pend = p;
  endtask

  task automatic push_region(input logic [15:0] b, input logic [7:0] skip);
    for (int j = 0; j < 8; j++)
      if (!skip[j]) exp_q.push_back(b + 16'(j));
  endtask

  task automatic drain(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, cur_req, "expected prefetches left unissued",
        16'(exp_q.size()), 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 16'h0, 16'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_addr = '0; dem_pend = '0;
    act_valid = 1'b0; act_bank = '0; act_row = '0;
    pres0 = 16'hFFFF; pres1 = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pf_valid && !probe_valid, "R9", "activity in reset", 16'(pf_valid), 16'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!pf_valid && !probe_valid, "R9", "activity after reset", 16'(probe_valid), 16'h0);
    end

    // R1/R6: one region, demand block excluded, ascending order
    cur_req = "R1";
    push_region(16'h0100, 8'h01);
    miss(16'h0100);
    drain(12);

    // R2: channel 1 busy, its blocks held back until it frees
    cur_req = "R2";
    set_pend(4'b0010);
    exp_q.push_back(16'h0202); exp_q.push_back(16'h0203); exp_q.push_back(16'h0204);
    exp_q.push_back(16'h0206); exp_q.push_back(16'h0207);
    miss(16'h0200);
    drain(12);
    exp_q.push_back(16'h0201); exp_q.push_back(16'h0205);
    set_pend(4'b0000);
    drain(8);

    // R3 then R6: open row in newer region wins once, then oldest region first
    cur_req = "R3";
    set_pend(4'hF);
    miss(16'h0400);
    miss(16'h0600);
    act(16'h0605);
    exp_q.push_back(16'h0605);
    push_region(16'h0400, 8'h01);
    push_region(16'h0600, 8'h21);
    set_pend(4'h0);
    drain(20);

    // R7: two regions share a row; hits go to the newer, misses to the older
    cur_req = "R7";
    set_pend(4'hF);
    miss(16'h0800);
    miss(16'h0808);
    act(16'h0802);
    exp_q.push_back(16'h080A); exp_q.push_back(16'h0802);
    for (int k = 1; k < 8; k++) begin
      if (k != 2) begin
        exp_q.push_back(16'h0800 + 16'(k));
        exp_q.push_back(16'h0808 + 16'(k));
      end
    end
    set_pend(4'h0);
    drain(20);

    // R4: resident or outstanding blocks are dropped
    cur_req = "R4";
    pres0 = 16'h0A03; pres1 = 16'h0A06;
    set_pend(4'hF);
    miss(16'h0A00);
    push_region(16'h0A00, 8'h49);
    set_pend(4'h0);
    drain(15);

    // R10/R1: refreshed region survives, untouched one is replaced and dropped
    cur_req = "R10";
    set_pend(4'hF);
    miss(16'h0C00);
    miss(16'h0E00);
    miss(16'h0C03);
    for (int k = 0; k < 7; k++) miss(16'h1000 + 16'(k) * 16'h0200);
    push_region(16'h0C00, 8'h09);
    for (int k = 0; k < 7; k++) push_region(16'h1000 + 16'(k) * 16'h0200, 8'h01);
    set_pend(4'h0);
    drain(70);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule